// File: doc/BRIEF.md
# Memory Type Resolver

This block decides which memory type applies to a physical address. It holds a small table that covers the lowest 1 MiB of the address space in equal segments. It also holds a configurable number of variable ranges, each defined by a base, a mask and a valid bit. When a lookup address is presented, the block finds every entry that covers it and merges the matching types under fixed priority rules. The result is a 3-bit type code and a flag that marks overlap combinations with no defined outcome.

Software configures the block through a simple register port. Writes take effect on the next clock edge. Reads are combinational. The port raises a one-cycle fault pulse for two kinds of write: a write to the read-only capability word, and a write that carries a type code the block does not support. A faulting write changes nothing. A global enable bit turns the whole mechanism off. While it is clear, every lookup resolves to uncacheable.

Top module: `memtype_resolver`

## Requirements
- R1: While the global enable bit (control bit 9) is 0, every lookup returns UC with the undefined flag low, whatever the ranges, the fixed table or the default field hold.
- R2: Register offset 0x00 reads the capability word: bits 7:0 hold the number of variable ranges, bit 8 is set when the fixed table exists, bit 10 is set when WC is supported, and all other bits read 0.
- R3: A write to offset 0x00 leaves the capability word unchanged and raises reg_fault in the cycle after the write.
- R4: The fixed table applies only when control bit 8 is set and the address is below 1 MiB. Entry i sits at offset 0x10+i and covers the i-th 64 KiB segment (with 16 entries). A fixed hit overrides every variable range and never sets the undefined flag.
- R5: Variable range k has a base word at offset 0x20+2k (bits 31:12 hold the base page, bits 2:0 hold the type) and a mask word at 0x21+2k (bits 31:12 hold the mask, bit 11 is valid). The range matches when it is valid and (page & mask) == (base & mask).
- R6: When every matching variable range carries the same type, that type is the result.
- R7: When any matching variable range is UC, the result is UC.
- R8: When the matching types are exactly WT and WB, the result is WT.
- R9: Any other mix of matching types sets res_undef and returns UC.
- R10: With the enable bit set and no range matching, the result is the default type held in control bits 2:0.
- R11: res_valid rises exactly one cycle after lk_valid and carries that lookup's result. res_valid is low after reset.
- R12: The type encodings are UC=0, WC=1, WT=4, WP=5 and WB=6. A write to the control word, a fixed entry or a base word whose type field holds any other code (or holds WC when WC is not supported) changes nothing and raises reg_fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| reg_fault | output | 1 | One-cycle pulse after a rejected write |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Physical address to resolve |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_type | output | 3 | Resolved memory type code |
| res_undef | output | 1 | Overlap combination with no defined result |

## Verification
The bench programs two nested variable ranges with every ordered pair of the five supported types. It looks up an address inside both ranges and one inside the outer range only. This separates the same-type, UC-wins, WT-over-WB and undefined branches, and confirms that a single match passes its type through. A second sweep fills all sixteen fixed entries over a variable range of a different type. It then reads one address in each segment, which separates fixed precedence and segment indexing from the fixed-enable bit. Further patterns cover default-type fallback, the valid bit, three-way overlaps, illegal type codes and the disabled state with undefined overlaps still programmed.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

    typedef enum logic [2:0] {
        MT_UC = 3'd0,
        MT_WC = 3'd1,
        MT_WT = 3'd4,
        MT_WP = 3'd5,
        MT_WB = 3'd6
    } mt_e;

    localparam int REG_AW        = 8;
    localparam int REG_DW        = 32;
    localparam int PAGE_SH       = 12;
    localparam int LOW_REGION_SH = 20;

    localparam logic [REG_AW-1:0] OFF_CAP  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_CTRL = 8'h01;
    localparam logic [REG_AW-1:0] OFF_FIX  = 8'h10;
    localparam logic [REG_AW-1:0] OFF_VAR  = 8'h20;

    localparam int CTRL_FE_BIT  = 8;
    localparam int CTRL_EN_BIT  = 9;
    localparam int MASK_VLD_BIT = 11;
    localparam int CAP_FIX_BIT  = 8;
    localparam int CAP_WC_BIT   = 10;

    localparam logic [7:0] SEEN_WT_WB = 8'h50;

    function automatic logic type_legal(input logic [2:0] code, input logic wc_ok);
        case (code)
            3'd0, 3'd4, 3'd5, 3'd6: return 1'b1;
            3'd1:                   return wc_ok;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mt_var_match.sv
module mt_var_match #(
    parameter int NUM_VAR = 8,
    parameter int PFN_W   = 20
) (
    input  logic [PFN_W-1:0]              pfn,
    input  logic [NUM_VAR-1:0][PFN_W-1:0] base,
    input  logic [NUM_VAR-1:0][PFN_W-1:0] mask,
    input  logic [NUM_VAR-1:0]            vld,
    input  logic [NUM_VAR-1:0][2:0]       vtyp,
    output logic [NUM_VAR-1:0]            hit,
    output logic [7:0]                    seen
);

    logic [NUM_VAR-1:0][7:0] onehot;

    for (genvar g = 0; g < NUM_VAR; g++) begin : g_range
        assign hit[g]    = vld[g] && ((pfn & mask[g]) == (base[g] & mask[g]));
        assign onehot[g] = hit[g] ? (8'd1 << vtyp[g]) : 8'd0;
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < NUM_VAR; i++) begin
            seen = seen | onehot[i];
        end
    end

endmodule

// File: rtl/mt_merge.sv
module mt_merge
    import memtype_pkg::*;
(
    input  logic [7:0] seen,
    input  logic [2:0] dflt,
    output logic [2:0] typ,
    output logic       undef
);

    logic       single;
    logic [2:0] idx;

    assign single = (seen != 8'd0) && ((seen & (seen - 8'd1)) == 8'd0);

    always_comb begin
        idx = 3'd0;
        for (int i = 0; i < 8; i++) begin
            if (seen[i]) idx = 3'(i);
        end
    end

    always_comb begin
        typ   = dflt;
        undef = 1'b0;
        if (seen == 8'd0) begin
            typ = dflt;
        end else if (single) begin
            typ = idx;
        end else if (seen[MT_UC]) begin
            typ = MT_UC;
        end else if (seen == SEEN_WT_WB) begin
            typ = MT_WT;
        end else begin
            typ   = MT_UC;
            undef = 1'b1;
        end
    end

endmodule

// File: rtl/mt_fixed_lookup.sv
module mt_fixed_lookup
    import memtype_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int FIX_ENTRIES = 16,
    parameter bit FIX_SUPPORT = 1'b1
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       fe,
    input  logic [FIX_ENTRIES-1:0][2:0] table_q,
    output logic                       hit,
    output logic [2:0]                 typ
);

    localparam int IDX_W = $clog2(FIX_ENTRIES);

    logic             in_low;
    logic [IDX_W-1:0] idx;

    assign in_low = (addr[ADDR_W-1:LOW_REGION_SH] == '0);
    assign idx    = addr[LOW_REGION_SH-1 -: IDX_W];
    assign typ    = table_q[idx];

    if (FIX_SUPPORT) begin : g_fix
        assign hit = fe && in_low;
    end else begin : g_nofix
        assign hit = 1'b0;
    end

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_VAR     = 8,
    parameter int FIX_ENTRIES = 16,
    parameter bit FIX_SUPPORT = 1'b1,
    parameter bit WC_SUPPORT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_fault,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic [2:0]        res_type,
    output logic              res_undef
);

    localparam int PFN_W     = ADDR_W - PAGE_SH;
    localparam int FIX_IDX_W = $clog2(FIX_ENTRIES);
    localparam int VAR_IDX_W = $clog2(NUM_VAR);

    typedef struct packed {
        logic                          en;
        logic                          fe;
        logic [2:0]                    dflt;
        logic [FIX_ENTRIES-1:0][2:0]   fix;
        logic [NUM_VAR-1:0][PFN_W-1:0] base;
        logic [NUM_VAR-1:0][PFN_W-1:0] mask;
        logic [NUM_VAR-1:0]            vld;
        logic [NUM_VAR-1:0][2:0]       vtyp;
        logic                          fault;
        logic                          res_v;
        logic [2:0]                    res_t;
        logic                          res_u;
    } st_t;

    st_t st_d, st_q;

    // lookup datapath
    logic [NUM_VAR-1:0] var_hit;
    logic [7:0]         seen;
    logic [2:0]         mrg_t;
    logic               mrg_u;
    logic               fix_hit;
    logic [2:0]         fix_t;

    mt_var_match #(
        .NUM_VAR (NUM_VAR),
        .PFN_W   (PFN_W)
    ) u_match (
        .pfn  (lk_addr[ADDR_W-1:PAGE_SH]),
        .base (st_q.base),
        .mask (st_q.mask),
        .vld  (st_q.vld),
        .vtyp (st_q.vtyp),
        .hit  (var_hit),
        .seen (seen)
    );

    mt_merge u_merge (
        .seen  (seen),
        .dflt  (st_q.dflt),
        .typ   (mrg_t),
        .undef (mrg_u)
    );

    mt_fixed_lookup #(
        .ADDR_W      (ADDR_W),
        .FIX_ENTRIES (FIX_ENTRIES),
        .FIX_SUPPORT (FIX_SUPPORT)
    ) u_fixed (
        .addr    (lk_addr),
        .fe      (st_q.fe),
        .table_q (st_q.fix),
        .hit     (fix_hit),
        .typ     (fix_t)
    );

    // register decode
    logic [REG_AW-1:0]    fix_rel;
    logic [REG_AW-1:0]    var_rel;
    logic                 fix_sel;
    logic                 var_sel;
    logic                 var_is_mask;
    logic [FIX_IDX_W-1:0] fix_idx;
    logic [VAR_IDX_W-1:0] var_idx;
    logic                 wtype_ok;
    logic [REG_DW-1:0]    cap_word;
    logic                 unused_bits;

    assign fix_rel     = reg_addr - OFF_FIX;
    assign var_rel     = reg_addr - OFF_VAR;
    assign fix_sel     = (reg_addr >= OFF_FIX) && (fix_rel < REG_AW'(FIX_ENTRIES));
    assign var_sel     = (reg_addr >= OFF_VAR) && (var_rel < REG_AW'(2 * NUM_VAR));
    assign var_is_mask = var_rel[0];
    assign fix_idx     = fix_rel[FIX_IDX_W-1:0];
    assign var_idx     = var_rel[VAR_IDX_W:1];
    assign wtype_ok    = type_legal(reg_wdata[2:0], WC_SUPPORT);
    assign unused_bits = ^{lk_addr[PAGE_SH-1:0], var_hit, fix_rel, var_rel, reg_wdata};

    always_comb begin
        cap_word              = '0;
        cap_word[7:0]         = 8'(NUM_VAR);
        cap_word[CAP_FIX_BIT] = FIX_SUPPORT;
        cap_word[CAP_WC_BIT]  = WC_SUPPORT;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_CAP) begin
            reg_rdata = cap_word;
        end else if (reg_addr == OFF_CTRL) begin
            reg_rdata[2:0]         = st_q.dflt;
            reg_rdata[CTRL_FE_BIT] = st_q.fe;
            reg_rdata[CTRL_EN_BIT] = st_q.en;
        end else if (fix_sel) begin
            reg_rdata[2:0] = st_q.fix[fix_idx];
        end else if (var_sel) begin
            if (var_is_mask) begin
                reg_rdata[PAGE_SH +: PFN_W] = st_q.mask[var_idx];
                reg_rdata[MASK_VLD_BIT]     = st_q.vld[var_idx];
            end else begin
                reg_rdata[PAGE_SH +: PFN_W] = st_q.base[var_idx];
                reg_rdata[2:0]              = st_q.vtyp[var_idx];
            end
        end
    end

    // next state
    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        st_d.res_v = lk_valid;

        if (lk_valid) begin
            if (!st_q.en) begin
                st_d.res_t = MT_UC;
                st_d.res_u = 1'b0;
            end else if (fix_hit) begin
                st_d.res_t = fix_t;
                st_d.res_u = 1'b0;
            end else begin
                st_d.res_t = mrg_t;
                st_d.res_u = mrg_u;
            end
        end

        if (reg_wr) begin
            if (reg_addr == OFF_CAP) begin
                st_d.fault = 1'b1;
            end else if (reg_addr == OFF_CTRL) begin
                if (wtype_ok) begin
                    st_d.dflt = reg_wdata[2:0];
                    st_d.fe   = reg_wdata[CTRL_FE_BIT];
                    st_d.en   = reg_wdata[CTRL_EN_BIT];
                end else begin
                    st_d.fault = 1'b1;
                end
            end else if (fix_sel && FIX_SUPPORT) begin
                if (wtype_ok) begin
                    st_d.fix[fix_idx] = reg_wdata[2:0];
                end else begin
                    st_d.fault = 1'b1;
                end
            end else if (var_sel) begin
                if (var_is_mask) begin
                    st_d.mask[var_idx] = reg_wdata[PAGE_SH +: PFN_W];
                    st_d.vld[var_idx]  = reg_wdata[MASK_VLD_BIT];
                end else if (wtype_ok) begin
                    st_d.base[var_idx] = reg_wdata[PAGE_SH +: PFN_W];
                    st_d.vtyp[var_idx] = reg_wdata[2:0];
                end else begin
                    st_d.fault = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_fault = st_q.fault;
    assign res_valid = st_q.res_v;
    assign res_type  = st_q.res_t;
    assign res_undef = st_q.res_u;

    // assertions
    p_off_gives_uc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !st_q.en) |=> (res_type == MT_UC && !res_undef));

    p_cap_write_faults_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CAP) |=> reg_fault);

    p_fixed_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && st_q.en && fix_hit) |=> (res_type == $past(fix_t) && !res_undef));

    p_uc_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && st_q.en && !fix_hit && seen[MT_UC]) |=> (res_type == MT_UC && !res_undef));

    p_wt_over_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && st_q.en && !fix_hit && seen == SEEN_WT_WB) |=> (res_type == MT_WT && !res_undef));

    p_undef_is_uc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_undef |-> res_type == MT_UC);

    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_idle_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    p_bad_code_faults_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CTRL && !type_legal(reg_wdata[2:0], WC_SUPPORT))
        |=> (reg_fault && $stable(st_q.dflt) && $stable(st_q.en)));

endmodule

// File: tb/memtype_resolver_bench.sv
module memtype_resolver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 4;
    localparam int NF         = 16;
    localparam logic [2:0] LEGAL [5] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        reg_fault;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = 32'd0;
    logic        res_valid;
    logic [2:0]  res_type;
    logic        res_undef;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    memtype_resolver #(
        .ADDR_W      (32),
        .NUM_VAR     (NV),
        .FIX_ENTRIES (NF),
        .FIX_SUPPORT (1'b1),
        .WC_SUPPORT  (1'b1)
    ) u_memtype_resolver (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_fault (reg_fault),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .res_valid (res_valid),
        .res_type  (res_type),
        .res_undef (res_undef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic flt);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        flt = reg_fault;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic look(input logic [31:0] a, output logic [2:0] t, output logic u, output logic v);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        t = res_type; u = res_undef; v = res_valid;
    endtask

    // expected merge of two matching types
    task automatic exp_pair(input logic [2:0] a, input logic [2:0] b,
                            output logic [2:0] t, output logic u, output string tag);
        u = 1'b0;
        if (a == b) begin
            t = a; tag = "R6";
        end else if (a == 3'd0 || b == 3'd0) begin
            t = 3'd0; tag = "R7";
        end else if ((a == 3'd4 && b == 3'd6) || (a == 3'd6 && b == 3'd4)) begin
            t = 3'd4; tag = "R8";
        end else begin
            t = 3'd0; u = 1'b1; tag = "R9";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        f;
        logic [2:0]  t;
        logic        u;
        logic        v;
        logic [2:0]  et;
        logic        eu;
        string       tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk("R11 reset res_valid", {31'd0, res_valid}, 32'd0);
        chk("R3 reset reg_fault", {31'd0, reg_fault}, 32'd0);
        rd(8'h00, d);
        chk("R2 capability word", d, 32'(NV) | (32'd1 << 8) | (32'd1 << 10));
        rd(8'h01, d);
        chk("R1 control after reset", d, 32'd0);

        // disabled after reset
        look(32'h0010_0000, t, u, v);
        chk("R1 disabled type", {29'd0, t}, 32'd0);
        chk("R1 disabled undef", {31'd0, u}, 32'd0);
        chk("R11 valid after one cycle", {31'd0, v}, 32'd1);
        @(negedge clk);
        chk("R11 valid drops", {31'd0, res_valid}, 32'd0);

        // capability write
        wr(8'h00, 32'hFFFF_FFFF, f);
        chk("R3 cap write fault", {31'd0, f}, 32'd1);
        rd(8'h00, d);
        chk("R3 cap unchanged", d, 32'(NV) | (32'd1 << 8) | (32'd1 << 10));

        // illegal default codes
        for (int c = 2; c < 8; c++) begin
            if (c == 2 || c == 3 || c == 7) begin
                wr(8'h01, 32'h0000_0300 | 32'(c), f);
                chk("R12 bad ctrl code fault", {31'd0, f}, 32'd1);
                rd(8'h01, d);
                chk("R12 ctrl unchanged", d, 32'd0);
            end
        end

        // enable, default fallback
        wr(8'h01, 32'h0000_0304, f);
        chk("R12 legal ctrl no fault", {31'd0, f}, 32'd0);
        look(32'h0200_0000, t, u, v);
        chk("R10 default WT", {29'd0, t}, 32'd4);
        wr(8'h01, 32'h0000_0306, f);
        look(32'h0200_0000, t, u, v);
        chk("R10 default WB", {29'd0, t}, 32'd6);
        chk("R10 default undef", {31'd0, u}, 32'd0);

        // pair sweep over two nested ranges
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                wr(8'h20, 32'h0010_0000 | 32'(LEGAL[i]), f);
                wr(8'h21, 32'hFFF0_0800, f);
                wr(8'h22, 32'h0010_0000 | 32'(LEGAL[j]), f);
                wr(8'h23, 32'hFFFF_0800, f);
                exp_pair(LEGAL[i], LEGAL[j], et, eu, tag);
                look(32'h0010_0040, t, u, v);
                chk({tag, " overlap type"}, {29'd0, t}, {29'd0, et});
                chk({tag, " overlap undef"}, {31'd0, u}, {31'd0, eu});
                look(32'h0018_0000, t, u, v);
                chk("R5 single match type", {29'd0, t}, {29'd0, LEGAL[i]});
                chk("R5 single match undef", {31'd0, u}, 32'd0);
            end
        end

        // valid bit
        wr(8'h20, 32'h0010_0006, f);
        wr(8'h22, 32'h0010_0000, f);
        wr(8'h23, 32'hFFFF_0000, f);
        look(32'h0010_0040, t, u, v);
        chk("R5 invalid range ignored", {29'd0, t}, 32'd6);

        // three-way overlaps
        wr(8'h20, 32'h0010_0004, f);
        wr(8'h22, 32'h0010_0006, f);
        wr(8'h23, 32'hFFFF_0800, f);
        wr(8'h24, 32'h0010_0006, f);
        wr(8'h25, 32'hFFFF_F800, f);
        look(32'h0010_0040, t, u, v);
        chk("R8 WT WB WB type", {29'd0, t}, 32'd4);
        chk("R8 WT WB WB undef", {31'd0, u}, 32'd0);
        wr(8'h24, 32'h0010_0005, f);
        look(32'h0010_0040, t, u, v);
        chk("R9 WT WB WP undef", {31'd0, u}, 32'd1);
        chk("R9 WT WB WP type", {29'd0, t}, 32'd0);

        // fixed table over a WB range covering the low 1 MiB
        wr(8'h26, 32'h0000_0006, f);
        wr(8'h27, 32'hFFF0_0800, f);
        for (int i = 0; i < NF; i++) begin
            wr(8'(8'h10 + i), 32'(LEGAL[i % 5]), f);
        end
        for (int i = 0; i < NF; i++) begin
            look(32'(i) << 16 | 32'h0000_1234, t, u, v);
            chk("R4 fixed entry type", {29'd0, t}, {29'd0, LEGAL[i % 5]});
            chk("R4 fixed entry undef", {31'd0, u}, 32'd0);
        end
        wr(8'h10, 32'h0000_0007, f);
        chk("R12 bad fixed code fault", {31'd0, f}, 32'd1);
        rd(8'h10, d);
        chk("R12 fixed entry unchanged", d, 32'd0);

        // fixed table disabled
        wr(8'h01, 32'h0000_0206, f);
        look(32'h0003_0000, t, u, v);
        chk("R4 fixed disabled uses range", {29'd0, t}, 32'd6);

        // global disable with undefined overlap still programmed
        wr(8'h01, 32'h0000_0106, f);
        look(32'h0003_0000, t, u, v);
        chk("R1 disabled low region", {29'd0, t}, 32'd0);
        look(32'h0010_0040, t, u, v);
        chk("R1 disabled overlap type", {29'd0, t}, 32'd0);
        chk("R1 disabled overlap undef", {31'd0, u}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule